// File: doc/BRIEF.md
# Multiplexed Peripheral Bus Master

This block runs a narrow external bus for the chip. Two PHY devices and one parallel boot EPROM hang off that bus. All of them share one 8-bit line group, which carries address bytes first and data after them. An external octal latch captures each address byte on its own active-high strobe. Each target has its own active-low select, and the block drives that select as a sustained tri-state line. It drives the select high before it releases it, and it leaves a floating clock before any select is driven again.

On the internal side, the block takes a one-clock request. The request gives a target, a direction, an address of up to 24 bits, write data and a 16-bit flag. The block returns the read data and a one-clock completion pulse. Two choices fix the shape of a bus cycle.

- **Address-16 pin mode.** This pin is sampled while reset is held. If the pin reads low, it becomes a third address strobe for EPROM bits 23:16. Otherwise it drives address bit 16 directly.
- **Parity mode.** When parity is enabled, the PHY 2 select pin carries odd parity over the byte lanes instead of a select. Every bus cycle then starts with one setup clock.

A 16-bit PHY access puts data bits 15:8 on a second set of lines. Its address is cut to one byte, so only one address phase is used.

Top module: `periphBusMaster`

## Requirements
- R1: `reqTarget` codes are 0 for PHY 1, 1 for PHY 2 and 2 for the EPROM. Bit k of `selN`/`selOe` belongs to target code k.
  - During an access, only the addressed target's select is driven low.
  - No other select is driven low at the same time.
- R2: The first address phase lasts one clock. In it, `strobeLo` is high and the byte lanes are driven with address bits 7:0.
- R3: The second address phase follows the first directly. In it, `strobeHi` is high for one clock with address bits 15:8 on the byte lanes.
  - It is used for EPROM accesses and for 8-bit PHY accesses.
  - It is not used for 16-bit PHY accesses.
- R4: `a16In` is sampled on every clock edge while `rstN` is low. `a16Oe` is low during reset and high afterwards.
  - If the sampled value is 0, `a16Out` strobes high for one clock after the second phase of an EPROM access, with address bits 23:16 on the byte lanes.
  - If the sampled value is 1, `a16Out` carries address bit 16 and there is no third phase.
- R5: While `cfgParityEn` is 1, select bit 1 is always driven. Its value makes the count of ones odd across that pin and the byte lanes. The byte lanes are taken as the driven value when `busDataOe` is 1 and as `busDataIn` otherwise. Each access then starts with one setup clock, which drives address bits 7:0 with no strobe. Requests for target 1 are ignored.
- R6: The 16-bit flag applies to PHY targets only.
  - A 16-bit write drives data bits 15:8 on `hiDataOut`.
  - A 16-bit read takes `rdData[15:8]` from `hiDataIn`.
  - Otherwise the high lines stay undriven and `rdData[15:8]` is 0.
- R7: The select is held low for `cfgWait`+1 clocks, starting in the clock after the last address phase. A read captures the input lines on the last of those clocks.
- R8: A write drives its data on the byte lanes from the first select-low clock through the clock after the select returns high. A read leaves the byte lanes undriven while the select is low.
- R9: After the last low clock, the select is driven high for exactly one clock and then floated. No select is driven in the clock in which a select is floated.
- R10: `busy` is high from the clock after acceptance until the access ends. `done` is high for exactly one clock, which is the floating clock. The following requests are ignored:
  - requests made while busy,
  - target code 3,
  - writes to the EPROM.
- R11: During reset, the following are all low: `selOe`, `busDataOe`, `hiDataOe`, `strobeLo`, `strobeHi`, `busy` and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous assert |
| reqValid | input | 1 | Request strobe, taken only when idle |
| reqTarget | input | 2 | Target code: 0 PHY 1, 1 PHY 2, 2 EPROM |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqWide | input | 1 | 16-bit PHY access |
| reqAddr | input | 24 | Access address |
| reqWdata | input | 16 | Write data |
| cfgParityEn | input | 1 | Use select bit 1 as the odd-parity pin |
| cfgWait | input | 4 | Data-phase length minus one |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rdData | output | 16 | Captured read data |
| busDataOut | output | 8 | Byte-lane output value |
| busDataOe | output | 1 | Byte-lane output enable |
| busDataIn | input | 8 | Byte-lane input value |
| hiDataOut | output | 8 | Upper data lines, 16-bit mode |
| hiDataOe | output | 1 | Upper data line enable |
| hiDataIn | input | 8 | Upper data line input |
| strobeLo | output | 1 | Address byte 0 latch strobe |
| strobeHi | output | 1 | Address byte 1 latch strobe |
| a16Out | output | 1 | Address bit 16 or third latch strobe |
| a16Oe | output | 1 | Enable for the address-16 pin |
| a16In | input | 1 | Strap value seen on the address-16 pin |
| selN | output | 3 | Active-low selects (bit 1 may carry parity) |
| selOe | output | 3 | Select output enables |

## Verification
The bench models the external latches and rebuilds each address from them in both strap settings. A design that drops or reorders a phase leaves a wrong byte in one of the latches.

The bench also targets the following faults:

- **Capture clock.** The read input changes on every select-low clock. Capture on any clock other than the last then returns a wrong value.
- **Release sequence.** The bench watches every select for the drive-high-then-float sequence and for the dead clock after it. A select that floats straight from low is reported.
- **Ignored requests.** Requests arrive while busy, for PHY 2 in parity mode, and for EPROM writes. A design that takes them shows extra select activity or a second done pulse.
- **Edge settings.** The bench covers wait settings of 0 and 15, and a parity pin that is followed over both driven and received bytes.

// File: rtl/pbusPkg.sv
package pbusPkg;

  localparam logic [1:0] TGT_PHY1 = 2'd0;
  localparam logic [1:0] TGT_PHY2 = 2'd1;
  localparam logic [1:0] TGT_ROM  = 2'd2;
  localparam logic [1:0] TGT_NONE = 2'd3;

  localparam int N_SEL   = 3;
  localparam int PAR_IDX = 1;

  // Strobes from control to datapath, one per bus-cycle action
  typedef struct packed {
    logic       loadReq;
    logic       drvAddr;
    logic [1:0] addrByte;
    logic       strobe0;
    logic       strobe1;
    logic       strobe2;
    logic       selLow;
    logic       selPark;
    logic       drvData;
    logic       capture;
    logic       done;
  } busStrobesT;

endpackage

// File: rtl/pbusCtrl.sv
module pbusCtrl
  import pbusPkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqTarget,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic              cfgParityEn,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              latchMode,
  output busStrobesT        strb,
  output logic              busy
);

  typedef enum logic [2:0] {
    S_IDLE, S_PSET, S_ADR0, S_ADR1, S_ADR2, S_SEL, S_PARK, S_REL
  } stateT;

  stateT             state, stateNx;
  logic [1:0]        tgtQ;
  logic              writeQ;
  logic              twoByteQ;
  logic [WAIT_W-1:0] waitQ;
  logic [WAIT_W-1:0] cntQ;
  logic              legal;
  logic              accept;
  logic              lastWait;
  logic              needThird;

  assign legal = (reqTarget != TGT_NONE)
               && !(reqTarget == TGT_PHY2 && cfgParityEn)
               && !(reqTarget == TGT_ROM && reqWrite);
  assign accept    = (state == S_IDLE) && reqValid && legal;
  assign lastWait  = (cntQ == waitQ);
  assign needThird = (tgtQ == TGT_ROM) && latchMode;

  always_comb begin
    stateNx = state;
    unique case (state)
      S_IDLE: if (accept) stateNx = cfgParityEn ? S_PSET : S_ADR0;
      S_PSET: stateNx = S_ADR0;
      S_ADR0: stateNx = twoByteQ ? S_ADR1 : S_SEL;
      S_ADR1: stateNx = needThird ? S_ADR2 : S_SEL;
      S_ADR2: stateNx = S_SEL;
      S_SEL:  if (lastWait) stateNx = S_PARK;
      S_PARK: stateNx = S_REL;
      S_REL:  stateNx = S_IDLE;
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      tgtQ     <= TGT_PHY1;
      writeQ   <= 1'b0;
      twoByteQ <= 1'b0;
      waitQ    <= '0;
      cntQ     <= '0;
    end else begin
      state <= stateNx;
      if (accept) begin
        tgtQ     <= reqTarget;
        writeQ   <= reqWrite;
        twoByteQ <= (reqTarget == TGT_ROM) || !reqWide;
        waitQ    <= cfgWait;
      end
      if (state != S_SEL) cntQ <= '0;
      else if (!lastWait) cntQ <= cntQ + 1'b1;
    end
  end

  always_comb begin
    strb          = '0;
    strb.loadReq  = accept;
    strb.drvAddr  = (state == S_PSET) || (state == S_ADR0)
                 || (state == S_ADR1) || (state == S_ADR2);
    strb.addrByte = (state == S_ADR1) ? 2'd1 : (state == S_ADR2) ? 2'd2 : 2'd0;
    strb.strobe0  = (state == S_ADR0);
    strb.strobe1  = (state == S_ADR1);
    strb.strobe2  = (state == S_ADR2);
    strb.selLow   = (state == S_SEL);
    strb.selPark  = (state == S_PARK);
    strb.drvData  = writeQ && ((state == S_SEL) || (state == S_PARK));
    strb.capture  = !writeQ && (state == S_SEL) && lastWait;
    strb.done     = (state == S_REL);
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/pbusDatapath.sv
module pbusDatapath
  import pbusPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  busStrobesT          strb,
  input  logic [1:0]          reqTarget,
  input  logic                reqWide,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2*BYTE_W-1:0] reqWdata,
  input  logic                cfgParityEn,
  input  logic [BYTE_W-1:0]   busDataIn,
  input  logic [BYTE_W-1:0]   hiDataIn,
  input  logic                a16In,
  output logic                latchMode,
  output logic                done,
  output logic [2*BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0]   busDataOut,
  output logic                busDataOe,
  output logic [BYTE_W-1:0]   hiDataOut,
  output logic                hiDataOe,
  output logic                strobeLo,
  output logic                strobeHi,
  output logic                a16Out,
  output logic                a16Oe,
  output logic [N_SEL-1:0]    selN,
  output logic [N_SEL-1:0]    selOe
);

  localparam int DIRECT_BIT = 2 * BYTE_W;

  logic [ADDR_W-1:0]   addrQ;
  logic [2*BYTE_W-1:0] wdataQ;
  logic [1:0]          tgtQ;
  logic                wideQ;
  logic [BYTE_W-1:0]   addrByteVal;
  logic [BYTE_W-1:0]   laneSeen;
  logic                parityBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      tgtQ   <= TGT_PHY1;
      wideQ  <= 1'b0;
    end else if (strb.loadReq) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      tgtQ   <= reqTarget;
      wideQ  <= reqWide && (reqTarget != TGT_ROM);
    end
  end

  // Strap: sampled on each edge while reset is held, then frozen
  always_ff @(posedge clk) begin
    if (!rstN) latchMode <= !a16In;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) a16Oe <= 1'b0;
    else       a16Oe <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.capture) begin
      rdData[BYTE_W-1:0]        <= busDataIn;
      rdData[2*BYTE_W-1:BYTE_W] <= wideQ ? hiDataIn : '0;
    end
  end

  assign addrByteVal = addrQ[strb.addrByte*BYTE_W +: BYTE_W];
  assign busDataOe   = strb.drvAddr || strb.drvData;
  assign busDataOut  = strb.drvAddr ? addrByteVal : wdataQ[BYTE_W-1:0];
  assign hiDataOe    = strb.drvData && wideQ;
  assign hiDataOut   = wdataQ[2*BYTE_W-1:BYTE_W];
  assign strobeLo    = strb.strobe0;
  assign strobeHi    = strb.strobe1;
  assign a16Out      = latchMode ? strb.strobe2 : addrQ[DIRECT_BIT];
  assign done        = strb.done;

  assign laneSeen  = busDataOe ? busDataOut : busDataIn;
  assign parityBit = ~^laneSeen;

  for (genvar i = 0; i < N_SEL; i++) begin : gSel
    logic mine;
    assign mine = (tgtQ == 2'(i));
    if (i == PAR_IDX) begin : gShared
      assign selN[i]  = cfgParityEn ? parityBit : !(strb.selLow && mine);
      assign selOe[i] = cfgParityEn || ((strb.selLow || strb.selPark) && mine);
    end else begin : gPlain
      assign selN[i]  = !(strb.selLow && mine);
      assign selOe[i] = (strb.selLow || strb.selPark) && mine;
    end
  end

endmodule

// File: rtl/periphBusMaster.sv
module periphBusMaster
  import pbusPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 24,
  parameter int WAIT_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqTarget,
  input  logic                reqWrite,
  input  logic                reqWide,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2*BYTE_W-1:0] reqWdata,
  input  logic                cfgParityEn,
  input  logic [WAIT_W-1:0]   cfgWait,
  output logic                busy,
  output logic                done,
  output logic [2*BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0]   busDataOut,
  output logic                busDataOe,
  input  logic [BYTE_W-1:0]   busDataIn,
  output logic [BYTE_W-1:0]   hiDataOut,
  output logic                hiDataOe,
  input  logic [BYTE_W-1:0]   hiDataIn,
  output logic                strobeLo,
  output logic                strobeHi,
  output logic                a16Out,
  output logic                a16Oe,
  input  logic                a16In,
  output logic [N_SEL-1:0]    selN,
  output logic [N_SEL-1:0]    selOe
);

  busStrobesT strb;
  logic       latchMode;

  pbusCtrl #(.WAIT_W(WAIT_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqTarget  (reqTarget),
    .reqWrite   (reqWrite),
    .reqWide    (reqWide),
    .cfgParityEn(cfgParityEn),
    .cfgWait    (cfgWait),
    .latchMode  (latchMode),
    .strb       (strb),
    .busy       (busy)
  );

  pbusDatapath #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqTarget  (reqTarget),
    .reqWide    (reqWide),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .cfgParityEn(cfgParityEn),
    .busDataIn  (busDataIn),
    .hiDataIn   (hiDataIn),
    .a16In      (a16In),
    .latchMode  (latchMode),
    .done       (done),
    .rdData     (rdData),
    .busDataOut (busDataOut),
    .busDataOe  (busDataOe),
    .hiDataOut  (hiDataOut),
    .hiDataOe   (hiDataOe),
    .strobeLo   (strobeLo),
    .strobeHi   (strobeHi),
    .a16Out     (a16Out),
    .a16Oe      (a16Oe),
    .selN       (selN),
    .selOe      (selOe)
  );

endmodule

// File: rtl/periphBusMasterChk.sv
module periphBusMasterChk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       busDataOe,
  input logic       strobeLo,
  input logic       strobeHi,
  input logic       cfgParityEn,
  input logic [2:0] selN,
  input logic [2:0] selOe
);

  logic [2:0] selMask;
  logic [2:0] lowVec;
  logic [2:0] highVec;
  logic [2:0] oeVec;

  assign selMask = {1'b1, !cfgParityEn, 1'b1};
  assign lowVec  = selOe & ~selN & selMask;
  assign highVec = selOe & selN & selMask;
  assign oeVec   = selOe & selMask;

  // R1
  one_sel_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lowVec));

  // R1
  sel_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lowVec != 3'b000) |-> busy);

  // R2
  strobe_lo_drives_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobeLo |-> busDataOe);

  // R3
  strobe_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobeHi |-> $past(strobeLo));

  // R7
  sel_after_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((lowVec != 3'b000) && ($past(lowVec) == 3'b000)) |-> $past(busDataOe));

  // R9
  park_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(lowVec) & ~lowVec & ~highVec) == 3'b000));

  // R9
  float_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(oeVec) & ~oeVec) != 3'b000) |-> (oeVec == 3'b000));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

endmodule

bind periphBusMaster periphBusMasterChk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .done       (done),
  .busDataOe  (busDataOe),
  .strobeLo   (strobeLo),
  .strobeHi   (strobeHi),
  .cfgParityEn(cfgParityEn),
  .selN       (selN),
  .selOe      (selOe)
);

// File: tb/tb_periphBusMaster.sv
module tb_periphBusMaster;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqTarget = 2'd0;
  logic        reqWrite = 1'b0;
  logic        reqWide = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        cfgParityEn = 1'b0;
  logic [3:0]  cfgWait = '0;
  logic        busy, done;
  logic [15:0] rdData;
  logic [7:0]  busDataOut, hiDataOut;
  logic        busDataOe, hiDataOe;
  logic [7:0]  busDataIn = '0;
  logic [7:0]  hiDataIn = '0;
  logic        strobeLo, strobeHi, a16Out, a16Oe;
  logic        a16In = 1'b1;
  logic [2:0]  selN, selOe;

  int  checks = 0;
  int  fails = 0;
  int  cycles = 0;
  bit  latchModeTb = 1'b0;
  bit  monOn = 1'b0;
  bit  ended = 1'b0;

  always #10 clk = ~clk;

  periphBusMaster dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTarget(reqTarget),
    .reqWrite(reqWrite), .reqWide(reqWide), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cfgParityEn(cfgParityEn), .cfgWait(cfgWait), .busy(busy), .done(done),
    .rdData(rdData), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busDataIn(busDataIn), .hiDataOut(hiDataOut), .hiDataOe(hiDataOe),
    .hiDataIn(hiDataIn), .strobeLo(strobeLo), .strobeHi(strobeHi),
    .a16Out(a16Out), .a16Oe(a16Oe), .a16In(a16In), .selN(selN), .selOe(selOe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic oddPar(input logic [7:0] v);
    return ~^v;
  endfunction

  function automatic logic [2:0] maskSel(input logic [2:0] v, input logic parEn);
    return v & {1'b1, !parEn, 1'b1};
  endfunction

  // Continuous monitor: parity pin and select release rule
  logic [2:0] prevLow = '0;
  logic [2:0] prevOe  = '0;
  always @(negedge clk) begin
    if (rstN && monOn) begin
      logic [2:0] lowV, highV, oeV;
      lowV  = maskSel(selOe & ~selN, cfgParityEn);
      highV = maskSel(selOe & selN, cfgParityEn);
      oeV   = maskSel(selOe, cfgParityEn);
      if (cfgParityEn)
        chk(selOe[1] && selN[1] == oddPar(busDataOe ? busDataOut : busDataIn),
            "R5", "parity pin", {selOe[1], selN[1]},
            {1'b1, oddPar(busDataOe ? busDataOut : busDataIn)});
      if ((prevLow & ~lowV) != 3'b000)
        chk((prevLow & ~lowV & ~highV) == 3'b000, "R9", "low select not parked high",
            highV, prevLow);
      if ((prevOe & ~oeV) != 3'b000)
        chk(oeV == 3'b000, "R9", "select driven in float clock", oeV, 0);
      prevLow <= lowV;
      prevOe  <= oeV;
    end else begin
      prevLow <= '0;
      prevOe  <= '0;
    end
  end

  task automatic doReset(input bit strapLow);
    monOn = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    reqValid = 1'b0;
    cfgParityEn = 1'b0;
    a16In = !strapLow;
    repeat (3) @(negedge clk);
    chk(selOe == 3'b000 && busDataOe == 1'b0 && hiDataOe == 1'b0, "R11",
        "reset drive enables", {selOe, busDataOe, hiDataOe}, 0);
    chk(!strobeLo && !strobeHi && !busy && !done, "R11", "reset strobes/status",
        {strobeLo, strobeHi, busy, done}, 0);
    chk(a16Oe == 1'b0, "R4", "a16 pin floated in reset", a16Oe, 0);
    rstN = 1'b1;
    latchModeTb = strapLow;
    @(negedge clk);
    chk(a16Oe == 1'b1, "R4", "a16 pin driven after reset", a16Oe, 1);
    monOn = 1'b1;
  endtask

  task automatic runAccess(input logic [1:0] tgt, input bit wr, input logic [23:0] addr,
                           input logic [15:0] wd, input bit wide, input logic [3:0] wt,
                           input bit poke);
    bit          isRom, effWide, exp1, exp2, parEn, doneSeen;
    int          s0, s1, s2, lowCnt, parkCnt, total;
    logic [7:0]  l0, l1, l2, rdB, rdH;
    logic        a16Seen;
    isRom   = (tgt == 2'd2);
    effWide = wide && !isRom;
    exp1    = !effWide;
    exp2    = isRom && latchModeTb;
    parEn   = cfgParityEn;
    s0 = 0; s1 = 0; s2 = 0; lowCnt = 0; parkCnt = 0; doneSeen = 0;
    l0 = '0; l1 = '0; l2 = '0; a16Seen = 1'b0;
    rdB = 8'($urandom); rdH = 8'($urandom);
    total = 1 + int'(exp1) + int'(exp2);

    reqValid = 1'b1; reqTarget = tgt; reqWrite = wr; reqAddr = addr;
    reqWdata = wd; reqWide = wide; cfgWait = wt;
    @(negedge clk);
    reqValid = poke;
    if (poke) begin
      reqTarget = 2'd0; reqWrite = 1'b0; reqAddr = ~addr; reqWide = !wide;
    end

    for (int cyc = 0; cyc < 64; cyc++) begin
      bit lowNow;
      lowNow = selOe[tgt] && !selN[tgt];
      if (cyc == 0 && parEn)
        chk(busDataOe && busDataOut == addr[7:0] && !strobeLo && !strobeHi, "R5",
            "parity setup clock", {busDataOe, busDataOut, strobeLo, strobeHi},
            {1'b1, addr[7:0], 2'b00});
      if (strobeLo) begin
        s0++; l0 = busDataOut;
        chk(busDataOe, "R2", "lanes driven with first strobe", busDataOe, 1);
      end
      if (strobeHi) begin
        s1++; l1 = busDataOut;
        chk(s0 == 1 && busDataOe, "R3", "second strobe after first", s0, 1);
      end
      if (latchModeTb && a16Out) begin
        s2++; l2 = busDataOut;
        chk(s1 == 1 && busDataOe, "R4", "third strobe after second", s1, 1);
      end
      if (lowNow) begin
        if (lowCnt == 0)
          chk(s0 + s1 + s2 == total && s0 == 1 && s1 == int'(exp1) && s2 == int'(exp2),
              "R3", "address phases before select", s0 + s1 + s2, total);
        lowCnt++;
        chk(maskSel(selOe & ~selN, parEn) == (3'b001 << tgt), "R1", "select vector",
            maskSel(selOe & ~selN, parEn), 3'b001 << tgt);
        if (wr) begin
          chk(busDataOe && busDataOut == wd[7:0], "R8", "write data while low",
              {busDataOe, busDataOut}, {1'b1, wd[7:0]});
          if (effWide)
            chk(hiDataOe && hiDataOut == wd[15:8], "R6", "wide write high byte",
                {hiDataOe, hiDataOut}, {1'b1, wd[15:8]});
        end else begin
          chk(!busDataOe, "R8", "read leaves lanes undriven", busDataOe, 0);
        end
        if (!effWide)
          chk(!hiDataOe, "R6", "high lines undriven", hiDataOe, 0);
        if (isRom && !latchModeTb) a16Seen = a16Out;
      end else if (lowCnt > 0 && selOe[tgt] && selN[tgt] && !done) begin
        parkCnt++;
        if (wr)
          chk(busDataOe && busDataOut == wd[7:0], "R8", "write data held in park",
              {busDataOe, busDataOut}, {1'b1, wd[7:0]});
      end
      if (done) begin
        doneSeen = 1;
        chk(parkCnt == 1, "R9", "park clocks", parkCnt, 1);
        chk(maskSel(selOe, parEn) == 3'b000, "R10", "done in float clock",
            maskSel(selOe, parEn), 0);
        chk(lowCnt == int'(wt) + 1, "R7", "select low clocks", lowCnt, int'(wt) + 1);
        chk(s0 == 1 && s1 == int'(exp1) && s2 == int'(exp2), "R3", "strobe counts",
            {s0[7:0], s1[7:0], s2[7:0]}, {8'd1, 7'd0, exp1, 7'd0, exp2});
        chk(l0 == addr[7:0], "R2", "latched byte 0", l0, addr[7:0]);
        if (exp1) chk(l1 == addr[15:8], "R3", "latched byte 1", l1, addr[15:8]);
        if (exp2) chk(l2 == addr[23:16], "R4", "latched byte 2", l2, addr[23:16]);
        if (isRom && !latchModeTb)
          chk(a16Seen == addr[16], "R4", "direct address bit 16", a16Seen, addr[16]);
        if (!wr)
          chk(rdData == {effWide ? rdH + 8'(wt) : 8'h00, rdB + 8'(wt)}, "R7",
              "captured read data", rdData, {effWide ? rdH + 8'(wt) : 8'h00, rdB + 8'(wt)});
        break;
      end else begin
        chk(busy, "R10", "busy during access", busy, 1);
      end
      #1;
      if (lowNow && !wr) begin
        busDataIn = rdB + 8'(lowCnt - 1);
        hiDataIn  = rdH + 8'(lowCnt - 1);
      end else begin
        busDataIn = 8'($urandom);
        hiDataIn  = 8'($urandom);
      end
      @(negedge clk);
    end
    chk(doneSeen, "R10", "access completed", doneSeen, 1);
    reqValid = 1'b0;
    @(negedge clk);
    chk(!busy && !done && maskSel(selOe, parEn) == 3'b000, "R10",
        "no extra access or done", {busy, done, selOe}, 0);
  endtask

  task automatic ignoredReq(input logic [1:0] tgt, input bit wr, input string req);
    reqValid = 1'b1; reqTarget = tgt; reqWrite = wr; reqAddr = 24'h00ABCD;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(!busy && !done && !busDataOe && maskSel(selOe, cfgParityEn) == 3'b000, req,
          "ignored request", {busy, done, busDataOe, selOe}, 0);
      @(negedge clk);
    end
  endtask

  task automatic randomAccess();
    logic [1:0] t;
    bit         w;
    t = 2'($urandom_range(0, 2));
    if (cfgParityEn && t == 2'd1) t = 2'd0;
    w = (t == 2'd2) ? 1'b0 : 1'($urandom);
    runAccess(t, w, 24'($urandom), 16'($urandom), 1'($urandom),
              4'($urandom), 1'($urandom));
  endtask

  initial begin
    void'($urandom(32'd7321));
    for (int m = 0; m < 2; m++) begin
      doReset(m == 0);
      runAccess(2'd0, 1'b1, 24'h12A55A, 16'hBEEF, 1'b0, 4'd2, 1'b0);
      runAccess(2'd1, 1'b0, 24'h00FF3C, 16'h0000, 1'b1, 4'd0, 1'b1);
      runAccess(2'd2, 1'b0, 24'hFFFFFF, 16'h0000, 1'b0, 4'd15, 1'b0);
      runAccess(2'd2, 1'b0, 24'h7E0001, 16'h0000, 1'b1, 4'd1, 1'b1);
      runAccess(2'd1, 1'b1, 24'h000081, 16'hC3A5, 1'b1, 4'd3, 1'b0);
      ignoredReq(2'd2, 1'b1, "R10");
      ignoredReq(2'd3, 1'b0, "R10");
      cfgParityEn = 1'b1;
      @(negedge clk);
      ignoredReq(2'd1, 1'b0, "R5");
      runAccess(2'd0, 1'b1, 24'h3355AA, 16'h7F01, 1'b1, 4'd0, 1'b0);
      runAccess(2'd2, 1'b0, 24'h010203, 16'h0000, 1'b0, 4'd4, 1'b0);
      for (int n = 0; n < 60; n++) begin
        if (n % 7 == 0) begin
          cfgParityEn = 1'($urandom);
          @(negedge clk);
        end
        randomAccess();
      end
      cfgParityEn = 1'b0;
      @(negedge clk);
    end
    ended = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !ended) begin
        ended = 1'b1;
        checks++;
        fails++;
        $display("FAIL R10 watchdog expired: actual %0d expected %0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

endmodule